// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Generator

This block raises the service requests for a synchronous serial port whose transmit and receive FIFOs each hold eight entries. It watches the two FIFO occupancy counts, a one-cycle pulse for every frame the receiver completes, and a one-cycle strobe for every receive FIFO pop. From these it builds four request sources: receive service, transmit service, receive overrun and receive timeout. Each source drives its own output, and one combined line carries the OR of all four. A controller can therefore use either one shared handler or a separate handler per source.

Software reaches the block through a plain register bus with one word per access. The bus accepts a write on every cycle in which `reg_wr` is high and never stalls, so there is no back-pressure. Reads have no side effects and are combinational on `reg_addr`. The control word holds three mask bits, one each for the receive, transmit and overrun sources, plus the port-enable bit. The timeout word holds the countdown reload value. The status word shows all four raw sources, before masking. A write-only clear word acknowledges an overrun. The occupancy inputs and the frame and pop pulses are plain status pins from the FIFO and shifter logic. They have no handshake.

The block holds the receive timeout counter and the sticky overrun flag. The FIFO storage, the shift engine and the system interrupt controller are outside it.

Top module: `sport_irq_unit`

## Requirements
- R1: Raw receive service (status bit 0) is 1 while `rx_level` is 4 or more and 0 while it is 3 or less.
- R2: Raw transmit service (status bit 1) is 1 while `tx_level` is 4 or less and 0 while it is 5 or more. The port-enable bit (control bit 4) has no effect on it.
- R3: Control bits 0, 1 and 2 enable the receive, transmit and overrun outputs. Each of these outputs is a register that samples its raw source ANDed with its mask bit, so it follows one clock edge later.
- R4: When `rx_frame_done` pulses while `rx_level` equals 8, the overrun flag (status bit 2) sets. It then stays set until it is cleared.
- R5: Overrun is cleared by a write to the clear word (address 3) with bit 2 set, or by any write to the control word (address 0). If a new overrun arrives in the same cycle as a clear, the flag stays set.
- R6: The timeout counter reloads on a frame pulse, on a pop strobe, or on a write to the timeout word (address 1). It counts down by one per cycle only while `rx_level` is non-zero. The timeout flag (status bit 3) sets on the edge at which the counter steps from 1 to 0, which is N counting cycles after a reload of N.
- R7: A timeout reload value of 0 disables the timeout, so the flag never sets.
- R8: Any write to the timeout word clears the timeout flag.
- R9: The timeout output has no mask: it follows the timeout flag one edge later, whatever the control bits hold.
- R10: `irq_any` is 1 exactly when at least one of the four individual outputs is 1.
- R11: After reset, the control word, the reload value, both flags and all outputs are 0.
- R12: Reading address 0 returns the control word (bits 0, 1, 2 and 4). Address 1 returns the reload value. Address 2 returns status, with receive service in bit 0, transmit service in bit 1, overrun in bit 2 and timeout in bit 3. Address 3 reads as 0. The `port_en` output mirrors control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_level | input | 4 | Transmit FIFO occupancy, 0 to 8 |
| rx_level | input | 4 | Receive FIFO occupancy, 0 to 8 |
| rx_frame_done | input | 1 | One-cycle pulse for each frame the receiver completes |
| rx_fifo_rd | input | 1 | One-cycle strobe for each receive FIFO pop |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| port_en | output | 1 | Port-enable control bit |
| irq_rx | output | 1 | Masked receive service request |
| irq_tx | output | 1 | Masked transmit service request |
| irq_ovr | output | 1 | Masked receive overrun request |
| irq_tmo | output | 1 | Receive timeout request, never masked |
| irq_any | output | 1 | OR of the four requests |

## Verification
The cases that are hardest to reach from the ports are those where two events meet on the same clock edge. One is an overrun frame that arrives in the very cycle software writes the clear word. The other is a timeout counter expiring exactly N counting cycles after its last reload. The bench drives the clear write and the full-FIFO frame pulse together inside one cycle, then expects the flag to survive. It counts clock edges from the reload edge, produced by a timeout-word write or a pop strobe, and reads the status one edge before and one edge at expiry. It also holds the receive FIFO empty for a while and confirms that the countdown pauses.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_TMO  = 2'd1,
    A_STAT = 2'd2,
    A_CLR  = 2'd3
  } reg_addr_e;

  localparam int unsigned B_RX  = 0;
  localparam int unsigned B_TX  = 1;
  localparam int unsigned B_OVR = 2;
  localparam int unsigned B_TMO = 3;
  localparam int unsigned B_EN  = 4;

  typedef struct packed {
    logic en;
    logic m_ovr;
    logic m_tx;
    logic m_rx;
  } ctrl_t;

  typedef struct packed {
    logic tmo;
    logic ovr;
    logic tx;
    logic rx;
  } src_t;

endpackage

// File: rtl/sport_irq_regs.sv
module sport_irq_regs
  import sport_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  src_t              raw,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [TMO_W-1:0]  reload,
  output logic              tmo_wr,
  output logic [TMO_W-1:0]  tmo_wval,
  output logic              ovr_clr
);

  reg_addr_e sel;
  assign sel      = reg_addr_e'(addr);
  assign tmo_wr   = wr_en && (sel == A_TMO);
  assign tmo_wval = wdata[TMO_W-1:0];
  assign ovr_clr  = wr_en && ((sel == A_CTRL) || ((sel == A_CLR) && wdata[B_OVR]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (wr_en) begin
      if (sel == A_CTRL) begin
        ctrl.m_rx  <= wdata[B_RX];
        ctrl.m_tx  <= wdata[B_TX];
        ctrl.m_ovr <= wdata[B_OVR];
        ctrl.en    <= wdata[B_EN];
      end
      if (sel == A_TMO) reload <= tmo_wval;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      A_CTRL: begin
        rdata[B_RX]  = ctrl.m_rx;
        rdata[B_TX]  = ctrl.m_tx;
        rdata[B_OVR] = ctrl.m_ovr;
        rdata[B_EN]  = ctrl.en;
      end
      A_TMO:  rdata[TMO_W-1:0] = reload;
      A_STAT: rdata[3:0] = raw;
      A_CLR:  rdata = '0;
      default: rdata = '0;
    endcase
  end

  // R5: a control write always acknowledges overrun
  p_ctrl_wr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == A_CTRL) |-> ovr_clr);

  // R12: control readback reflects the last control write
  p_ctrl_readback_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == A_CTRL) |=> (ctrl.en == $past(wdata[B_EN])));

endmodule

// File: rtl/sport_irq_level.sv
module sport_irq_level #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned RX_HI = 4,
  parameter int unsigned TX_LO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  output logic             rx_req,
  output logic             tx_req
);

  localparam logic [CNT_W-1:0] RX_ON = CNT_W'(RX_HI);
  localparam logic [CNT_W-1:0] TX_ON = CNT_W'(TX_LO);

  assign rx_req = (rx_level >= RX_ON);
  assign tx_req = (tx_level <= TX_ON);

  // R1: below the threshold the receive request is low
  p_rx_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level < RX_ON) |-> !rx_req);

  // R2: above the threshold the transmit request is low
  p_tx_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level > TX_ON) |-> !tx_req);

endmodule

// File: rtl/sport_irq_ovr.sv
module sport_irq_ovr #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             frame_done,
  input  logic             clr,
  output logic             flag
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic hit;
  assign hit = frame_done && (rx_level == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R4: a frame into a full FIFO raises overrun
  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R4: overrun is sticky until acknowledged
  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R5: acknowledge without a new overrun drops the flag
  p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);

endmodule

// File: rtl/sport_irq_tmo.sv
module sport_irq_tmo #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             frame_done,
  input  logic             fifo_rd,
  input  logic [TMO_W-1:0] reload,
  input  logic             tmo_wr,
  input  logic [TMO_W-1:0] tmo_wval,
  output logic             flag
);

  logic [TMO_W-1:0] cnt;
  logic             run;

  assign run = (rx_level != '0) && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (tmo_wr) begin
      cnt  <= tmo_wval;
      flag <= 1'b0;
    end else if (frame_done || fifo_rd) begin
      cnt <= reload;
    end else if (run) begin
      cnt <= cnt - 1'b1;
      if ((cnt == TMO_W'(1)) && (reload != '0)) flag <= 1'b1;
    end
  end

  // R8: a timeout-word write clears the flag
  p_tmo_wr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_wr |=> !flag);

  // R6: the count never exceeds the reload value
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= reload);

  // R7: with a zero reload the flag cannot rise
  p_tmo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0 && !flag) |=> !flag);

  // R6: with the receive FIFO empty the count holds
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0 && !tmo_wr && !frame_done && !fifo_rd) |=> $stable(cnt));

endmodule

// File: rtl/sport_irq_out.sv
module sport_irq_out
  import sport_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  src_t       raw,
  input  logic [2:0] mask,
  output logic [3:0] irq,
  output logic       irq_any
);

  logic [3:0] raw_v;
  logic [3:0] gated;

  assign raw_v = raw;

  generate
    for (genvar i = 0; i < 3; i++) begin : g_masked
      assign gated[i] = raw_v[i] & mask[i];
    end
  endgenerate
  assign gated[B_TMO] = raw_v[B_TMO];

  generate
    for (genvar i = 0; i < 4; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq[i] <= 1'b0;
        else        irq[i] <= gated[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_any <= 1'b0;
    else        irq_any <= |gated;
  end

  // R10: combined output agrees with the individual outputs
  p_any_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == ($countones(irq) != 0));

  // R3: a cleared mask keeps the receive output low next cycle
  p_rx_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[B_RX] |=> !irq[B_RX]);

  // R9: timeout output follows the flag with no mask
  p_tmo_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    raw.tmo |=> irq[B_TMO]);

endmodule

// File: rtl/sport_irq_unit.sv
module sport_irq_unit
  import sport_irq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned RX_HI  = 4,
  parameter int unsigned TX_LO  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TMO_W  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              rx_frame_done,
  input  logic              rx_fifo_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              port_en,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_ovr,
  output logic              irq_tmo,
  output logic              irq_any
);

  ctrl_t            ctrl;
  src_t             raw;
  logic [TMO_W-1:0] reload;
  logic [TMO_W-1:0] tmo_wval;
  logic             tmo_wr;
  logic             ovr_clr;
  logic             rx_req;
  logic             tx_req;
  logic             ovr_flag;
  logic             tmo_flag;
  logic [3:0]       irq_v;

  assign raw.rx  = rx_req;
  assign raw.tx  = tx_req;
  assign raw.ovr = ovr_flag;
  assign raw.tmo = tmo_flag;

  sport_irq_regs #(.DATA_W(DATA_W), .TMO_W(TMO_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .raw(raw), .rdata(reg_rdata), .ctrl(ctrl), .reload(reload),
    .tmo_wr(tmo_wr), .tmo_wval(tmo_wval), .ovr_clr(ovr_clr)
  );

  sport_irq_level #(.CNT_W(CNT_W), .RX_HI(RX_HI), .TX_LO(TX_LO)) level_i (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_req(rx_req), .tx_req(tx_req)
  );

  sport_irq_ovr #(.CNT_W(CNT_W), .DEPTH(DEPTH)) ovr_i (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .frame_done(rx_frame_done),
    .clr(ovr_clr), .flag(ovr_flag)
  );

  sport_irq_tmo #(.CNT_W(CNT_W), .TMO_W(TMO_W)) tmo_i (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .frame_done(rx_frame_done),
    .fifo_rd(rx_fifo_rd), .reload(reload), .tmo_wr(tmo_wr), .tmo_wval(tmo_wval),
    .flag(tmo_flag)
  );

  sport_irq_out out_i (
    .clk(clk), .rst_n(rst_n), .raw(raw),
    .mask({ctrl.m_ovr, ctrl.m_tx, ctrl.m_rx}),
    .irq(irq_v), .irq_any(irq_any)
  );

  assign port_en = ctrl.en;
  assign irq_rx  = irq_v[B_RX];
  assign irq_tx  = irq_v[B_TX];
  assign irq_ovr = irq_v[B_OVR];
  assign irq_tmo = irq_v[B_TMO];

  // R2: transmit request ignores the port-enable bit
  p_tx_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && tx_level == '0) |-> raw.tx);

endmodule

// File: tb/sport_irq_unit_tb.sv
module sport_irq_unit_tb_top;

  localparam time CLK_T = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tx_level = '0;
  logic [3:0]  rx_level = '0;
  logic        rx_frame_done = 1'b0;
  logic        rx_fifo_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        port_en, irq_rx, irq_tx, irq_ovr, irq_tmo, irq_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_T / 2) clk = ~clk;

  sport_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_frame_done(rx_frame_done), .rx_fifo_rd(rx_fifo_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_en(port_en), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ovr(irq_ovr),
    .irq_tmo(irq_tmo), .irq_any(irq_any)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic stat_bit(input int b, input logic exp, input string tag);
    logic [15:0] d;
    rd(2'd2, d);
    check({15'd0, d[b]}, {15'd0, exp}, tag);
  endtask

  task automatic pulse_frame();
    rx_frame_done = 1'b1;
    @(negedge clk);
    rx_frame_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check(d, 16'h0000, "R11 ctrl after reset");
    rd(2'd1, d); check(d, 16'h0000, "R11 reload after reset");
    rd(2'd2, d); check(d, 16'h0002, "R11 status after reset");
    rd(2'd3, d); check(d, 16'h0000, "R12 clear word reads zero");
    check({10'd0, port_en, irq_rx, irq_tx, irq_ovr, irq_tmo, irq_any}, 16'h0, "R11 outputs after reset");
  endtask

  task automatic t_rx_thresh();
    rx_level = 4'd3; stat_bit(0, 1'b0, "R1 rx at 3");
    rx_level = 4'd4; stat_bit(0, 1'b1, "R1 rx at 4");
    rx_level = 4'd8; stat_bit(0, 1'b1, "R1 rx at 8");
    rx_level = 4'd3; stat_bit(0, 1'b0, "R1 rx back to 3");
    rx_level = 4'd0; step(1);
  endtask

  task automatic t_tx_thresh();
    logic [15:0] d;
    tx_level = 4'd4; stat_bit(1, 1'b1, "R2 tx at 4");
    tx_level = 4'd5; stat_bit(1, 1'b0, "R2 tx at 5");
    tx_level = 4'd8; stat_bit(1, 1'b0, "R2 tx at 8");
    wr(2'd0, 16'h0010);
    rd(2'd0, d); check(d, 16'h0010, "R12 ctrl readback enable");
    check({15'd0, port_en}, 16'h1, "R12 port_en mirrors bit 4");
    tx_level = 4'd3; stat_bit(1, 1'b1, "R2 tx at 3 with port enabled");
    wr(2'd0, 16'h0000);
    tx_level = 4'd0; stat_bit(1, 1'b1, "R2 tx at 0 with port disabled");
  endtask

  task automatic t_masks();
    logic [15:0] d;
    rx_level = 4'd5; tx_level = 4'd2;
    step(1);
    wr(2'd0, 16'h0001);
    check({15'd0, irq_rx}, 16'h0, "R3 rx output lags mask by one edge");
    step(1);
    check({12'd0, irq_rx, irq_tx, irq_ovr, irq_any}, 16'b1001, "R3 rx only enabled");
    wr(2'd0, 16'h0002);
    step(1);
    check({12'd0, irq_rx, irq_tx, irq_ovr, irq_any}, 16'b0101, "R3 tx only enabled");
    rd(2'd0, d); check(d, 16'h0002, "R12 ctrl readback masks");
    wr(2'd0, 16'h0000);
    step(1);
    check({14'd0, irq_tx, irq_any}, 16'b00, "R10 all masked gives no combined");
    rx_level = 4'd0; tx_level = 4'd8;
    step(1);
  endtask

  task automatic t_overrun();
    wr(2'd0, 16'h0004);
    rx_level = 4'd7; pulse_frame();
    stat_bit(2, 1'b0, "R4 no overrun below full");
    rx_level = 4'd8; pulse_frame();
    stat_bit(2, 1'b1, "R4 overrun on full");
    step(1);
    check({14'd0, irq_ovr, irq_any}, 16'b11, "R3 overrun output enabled");
    step(3);
    stat_bit(2, 1'b1, "R4 overrun sticky");
    wr(2'd3, 16'h000B);
    stat_bit(2, 1'b1, "R5 clear without bit 2 ignored");
    wr(2'd3, 16'h0004);
    stat_bit(2, 1'b0, "R5 clear word acknowledges");
    pulse_frame();
    stat_bit(2, 1'b1, "R4 overrun set again");
    wr(2'd0, 16'h0004);
    stat_bit(2, 1'b0, "R5 control write acknowledges");
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0004; rx_frame_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; rx_frame_done = 1'b0;
    stat_bit(2, 1'b1, "R5 new overrun wins over clear");
    wr(2'd0, 16'h0000);
    rx_level = 4'd0;
    step(2);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    rx_level = 4'd2;
    wr(2'd1, 16'd5);
    step(4); stat_bit(3, 1'b0, "R6 no timeout one cycle early");
    step(1); stat_bit(3, 1'b1, "R6 timeout after 5 cycles");
    step(1);
    check({14'd0, irq_tmo, irq_any}, 16'b11, "R9 timeout output with masks clear");
    wr(2'd1, 16'd5);
    stat_bit(3, 1'b0, "R8 timeout write clears flag");
    step(3);
    rx_fifo_rd = 1'b1; @(negedge clk); rx_fifo_rd = 1'b0;
    step(4); stat_bit(3, 1'b0, "R6 pop reloads counter");
    step(1); stat_bit(3, 1'b1, "R6 timeout after reload from pop");
    rx_level = 4'd0;
    wr(2'd1, 16'd3);
    step(10); stat_bit(3, 1'b0, "R6 count holds while FIFO empty");
    rx_level = 4'd1;
    step(2); stat_bit(3, 1'b0, "R6 resumed count not yet expired");
    step(1); stat_bit(3, 1'b1, "R6 resumed count expires");
    wr(2'd1, 16'd0);
    stat_bit(3, 1'b0, "R8 zero write clears flag");
    step(20); stat_bit(3, 1'b0, "R7 zero reload disables timeout");
    rd(2'd1, d); check(d, 16'h0000, "R12 reload readback");
    check({15'd0, irq_tmo}, 16'h0, "R9 output follows cleared flag");
    rx_level = 4'd0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_rx_thresh();
    t_tx_thresh();
    t_masks();
    t_overrun();
    t_timeout();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule